// File: doc/BRIEF.md
# Bipolar Stepper Phase Sequencer

This block turns step commands into the on/off and polarity pattern for the two windings of a bipolar stepper motor. It keeps a motor position as one of eight named states. One eight-entry table serves both step modes. Each rising edge on the asynchronous step input moves the position by one table entry in half-step mode, or to the next two-windings-on entry in full-step mode. A direction input chooses the rotation sense. The four outputs give an enable and a polarity for each winding, and go to two bridge chopper controllers. A winding whose enable is low is held off by its chopper.

The step input is brought into the system clock domain through a synchronizer chain, and its rising edge is detected there. Direction and mode are sampled on the system clock edge that applies the move. They are assumed to be quasi-static around a step, since the step input's own setup and hold windows are microseconds long. The reset input sets the position to a fixed home state with both windings driven positive.

The states, listed in clockwise order with their drive patterns, are:

| State | Winding A | Winding B |
|---|---|---|
| `ST_AP_BP` | positive | positive |
| `ST_A0_BP` | off | positive |
| `ST_AN_BP` | negative | positive |
| `ST_AN_B0` | negative | off |
| `ST_AN_BN` | negative | negative |
| `ST_A0_BN` | off | negative |
| `ST_AP_BN` | positive | negative |
| `ST_AP_B0` | positive | off |

There are five move kinds:
- `MV_HOLD`: no step edge was detected.
- `MV_HALF_FWD` and `MV_HALF_REV`: one entry forward or back.
- `MV_FULL_FWD` and `MV_FULL_REV`: two entries from a two-on state.
- From a one-winding state in full-step mode, the same two full moves take one entry, which aligns the position onto the adjacent two-on state.

Top module: `stepper_phase_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no step edge, the outputs show the home state: a_en=1, a_pos=1, b_en=1, b_pos=1.
- R2: Each rising edge of step_in causes exactly one position move, and the outputs reflect it within 4 system clocks. Holding step_in high or low causes no further move.
- R3: With half_mode=1 and dir_cw=1, the states follow the clockwise order of the state table, one entry per step, and wrap from `ST_AP_B0` back to `ST_AP_BP`.
- R4: With half_mode=1 and dir_cw=0, the states follow the same table in reverse order and wrap from `ST_AP_BP` to `ST_AP_B0`.
- R5: With half_mode=0, a step taken from a two-on state advances by two entries, to the next two-on state. The direction is clockwise when dir_cw=1 and the reverse when dir_cw=0.
- R6: With half_mode=0, a step taken from a one-winding state moves by one entry in the chosen direction, onto the adjacent two-on state.
- R7: A winding that is not energized has its enable at 0 and its polarity at 0, and at least one winding is always enabled. A polarity of 1 means positive drive and 0 means negative drive.
- R8: If step_in is already high when reset is released, no move occurs until step_in has gone low and risen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset to the home state |
| step_in | input | 1 | Asynchronous step clock; a rising edge requests one move |
| dir_cw | input | 1 | 1 = clockwise, 0 = counterclockwise |
| half_mode | input | 1 | 1 = half-step, 0 = full-step |
| a_en | output | 1 | Winding A energized |
| a_pos | output | 1 | Winding A polarity (1 positive, 0 negative) |
| b_en | output | 1 | Winding B energized |
| b_pos | output | 1 | Winding B polarity (1 positive, 0 negative) |

## Verification
A wrong position state is visible at the four outputs as soon as it is entered, because the outputs are decoded directly from the state register. A lost step, a doubled step or a wrong step size therefore appears within four system clocks of the step edge. It persists until the next reset, so every later comparison against the arithmetic position model also fails. A bad decode entry appears as a winding that is energized when it should be off, or that has the wrong polarity, and only in that one state. For this reason the sweeps visit all eight states in both directions.

// File: rtl/stepper_seq_pkg.sv
package stepper_seq_pkg;

    localparam int POS_W = 3;

    typedef enum logic [POS_W-1:0] {
        ST_AP_BP = 3'd0,
        ST_A0_BP = 3'd1,
        ST_AN_BP = 3'd2,
        ST_AN_B0 = 3'd3,
        ST_AN_BN = 3'd4,
        ST_A0_BN = 3'd5,
        ST_AP_BN = 3'd6,
        ST_AP_B0 = 3'd7
    } pos_t;

    typedef enum logic [2:0] {
        MV_HOLD,
        MV_HALF_FWD,
        MV_HALF_REV,
        MV_FULL_FWD,
        MV_FULL_REV
    } move_t;

    typedef struct packed {
        logic a_en;
        logic a_pos;
        logic b_en;
        logic b_pos;
    } drive_t;

    localparam pos_t HOME_POS = ST_AP_BP;

endpackage

// File: rtl/step_edge_sync.sv
module step_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_in,
    output logic step_pulse
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    // Reset to 1: a step level already high at release is not an edge.
    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= step_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[LAST-1:0], step_in};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[LAST];
    end

    assign step_pulse = chain_q[LAST] & ~prev_q;

endmodule

// File: rtl/step_position_fsm.sv
module step_position_fsm
    import stepper_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step_pulse,
    input  logic dir_cw,
    input  logic half_mode,
    output pos_t pos_q
);

    move_t move;
    pos_t  nxt_pos;
    pos_t  fwd_half, rev_half, fwd_full, rev_full;

    // Move selection
    always_comb begin
        if (!step_pulse)            move = MV_HOLD;
        else if (half_mode &&  dir_cw) move = MV_HALF_FWD;
        else if (half_mode)            move = MV_HALF_REV;
        else if (dir_cw)               move = MV_FULL_FWD;
        else                           move = MV_FULL_REV;
    end

    // Per-state neighbours; full moves from one-winding states align by one
    always_comb begin
        fwd_half = pos_q;
        rev_half = pos_q;
        fwd_full = pos_q;
        rev_full = pos_q;
        unique case (pos_q)
            ST_AP_BP: begin
                fwd_half = ST_A0_BP; rev_half = ST_AP_B0;
                fwd_full = ST_AN_BP; rev_full = ST_AP_BN;
            end
            ST_A0_BP: begin
                fwd_half = ST_AN_BP; rev_half = ST_AP_BP;
                fwd_full = ST_AN_BP; rev_full = ST_AP_BP;
            end
            ST_AN_BP: begin
                fwd_half = ST_AN_B0; rev_half = ST_A0_BP;
                fwd_full = ST_AN_BN; rev_full = ST_AP_BP;
            end
            ST_AN_B0: begin
                fwd_half = ST_AN_BN; rev_half = ST_AN_BP;
                fwd_full = ST_AN_BN; rev_full = ST_AN_BP;
            end
            ST_AN_BN: begin
                fwd_half = ST_A0_BN; rev_half = ST_AN_B0;
                fwd_full = ST_AP_BN; rev_full = ST_AN_BP;
            end
            ST_A0_BN: begin
                fwd_half = ST_AP_BN; rev_half = ST_AN_BN;
                fwd_full = ST_AP_BN; rev_full = ST_AN_BN;
            end
            ST_AP_BN: begin
                fwd_half = ST_AP_B0; rev_half = ST_A0_BN;
                fwd_full = ST_AP_BP; rev_full = ST_AN_BN;
            end
            ST_AP_B0: begin
                fwd_half = ST_AP_BP; rev_half = ST_AP_BN;
                fwd_full = ST_AP_BP; rev_full = ST_AP_BN;
            end
            default: ;
        endcase
    end

    always_comb begin
        unique case (move)
            MV_HALF_FWD: nxt_pos = fwd_half;
            MV_HALF_REV: nxt_pos = rev_half;
            MV_FULL_FWD: nxt_pos = fwd_full;
            MV_FULL_REV: nxt_pos = rev_full;
            default:     nxt_pos = pos_q;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= HOME_POS;
        else        pos_q <= nxt_pos;
    end

endmodule

// File: rtl/phase_drive_decode.sv
module phase_drive_decode
    import stepper_seq_pkg::*;
(
    input  pos_t   pos,
    output drive_t drive
);

    // Output process: {a_en, a_pos, b_en, b_pos}
    always_comb begin
        drive = '0;
        unique case (pos)
            ST_AP_BP: drive = '{a_en: 1'b1, a_pos: 1'b1, b_en: 1'b1, b_pos: 1'b1};
            ST_A0_BP: drive = '{a_en: 1'b0, a_pos: 1'b0, b_en: 1'b1, b_pos: 1'b1};
            ST_AN_BP: drive = '{a_en: 1'b1, a_pos: 1'b0, b_en: 1'b1, b_pos: 1'b1};
            ST_AN_B0: drive = '{a_en: 1'b1, a_pos: 1'b0, b_en: 1'b0, b_pos: 1'b0};
            ST_AN_BN: drive = '{a_en: 1'b1, a_pos: 1'b0, b_en: 1'b1, b_pos: 1'b0};
            ST_A0_BN: drive = '{a_en: 1'b0, a_pos: 1'b0, b_en: 1'b1, b_pos: 1'b0};
            ST_AP_BN: drive = '{a_en: 1'b1, a_pos: 1'b1, b_en: 1'b1, b_pos: 1'b0};
            ST_AP_B0: drive = '{a_en: 1'b1, a_pos: 1'b1, b_en: 1'b0, b_pos: 1'b0};
            default:  drive = '0;
        endcase
    end

endmodule

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq
    import stepper_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_in,
    input  logic dir_cw,
    input  logic half_mode,
    output logic a_en,
    output logic a_pos,
    output logic b_en,
    output logic b_pos
);

    logic             step_pulse;
    pos_t             pos_q;
    drive_t           drive;
    logic [POS_W-1:0] pos_bits;

    step_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_in    (step_in),
        .step_pulse (step_pulse)
    );

    step_position_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_pulse (step_pulse),
        .dir_cw     (dir_cw),
        .half_mode  (half_mode),
        .pos_q      (pos_q)
    );

    phase_drive_decode u_dec (
        .pos   (pos_q),
        .drive (drive)
    );

    assign pos_bits = pos_q;
    assign a_en     = drive.a_en;
    assign a_pos    = drive.a_pos;
    assign b_en     = drive.b_en;
    assign b_pos    = drive.b_pos;

endmodule

// File: rtl/stepper_phase_seq_chk.sv
module stepper_phase_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dir_cw,
    input logic       half_mode,
    input logic       step_pulse,
    input logic [2:0] pos,
    input logic       a_en,
    input logic       a_pos,
    input logic       b_en,
    input logic       b_pos
);

    assert_home_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (a_en && a_pos && b_en && b_pos));

    assert_hold_without_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step_pulse |=> $stable(pos));

    assert_half_fwd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_pulse && half_mode && dir_cw) |=> (pos == 3'($past(pos) + 3'd1)));

    assert_half_rev_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_pulse && half_mode && !dir_cw) |=> (pos == 3'($past(pos) - 3'd1)));

    assert_full_lands_two_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_pulse && !half_mode) |=> (a_en && b_en));

    assert_align_one_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_pulse && !half_mode && !(a_en && b_en)) |=> !$stable(a_en && b_en));

    assert_off_polarity_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_en |-> !a_pos) and (!b_en |-> !b_pos));

    assert_one_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({a_en, b_en}) >= 1);

endmodule

bind stepper_phase_seq stepper_phase_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dir_cw     (dir_cw),
    .half_mode  (half_mode),
    .step_pulse (step_pulse),
    .pos        (pos_bits),
    .a_en       (a_en),
    .a_pos      (a_pos),
    .b_en       (b_en),
    .b_pos      (b_pos)
);

// File: tb/tb_stepper_phase_seq.sv
module tb_stepper_phase_seq;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_in = 1'b0;
    logic dir_cw = 1'b1;
    logic half_mode = 1'b1;
    logic a_en, a_pos, b_en, b_pos;

    int checks = 0;
    int errors = 0;
    int model_pos = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    stepper_phase_seq dut (
        .clk(clk), .rst_n(rst_n), .step_in(step_in), .dir_cw(dir_cw),
        .half_mode(half_mode), .a_en(a_en), .a_pos(a_pos),
        .b_en(b_en), .b_pos(b_pos)
    );

    function automatic logic [3:0] expect_drive(input int p);
        logic ae, ap, be, bp;
        ae = ((p % 4) != 1);
        be = ((p % 4) != 3);
        ap = ae && (p == 0 || p >= 6);
        bp = be && (p <= 2);
        return {ae, ap, be, bp};
    endfunction

    task automatic check_pos(input string req);
        logic [3:0] exp_v;
        exp_v = expect_drive(model_pos);
        checks++;
        if ({a_en, a_pos, b_en, b_pos} !== exp_v) begin
            errors++;
            $display("FAIL %s pos=%0d actual=%b expected=%b", req, model_pos,
                     {a_en, a_pos, b_en, b_pos}, exp_v);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_step(input logic cw, input logic half, input string req);
        int delta;
        dir_cw = cw;
        half_mode = half;
        wait_n(2);
        step_in = 1'b1;
        wait_n(6);
        if (half || (model_pos % 2 == 1)) delta = 1;
        else delta = 2;
        model_pos = (model_pos + (cw ? delta : 8 - delta)) % 8;
        check_pos(req);
        wait_n(10);
        step_in = 1'b0;
        wait_n(6);
        check_pos("R2");
    endtask

    initial begin
        wait_n(3);
        check_pos("R1");
        rst_n = 1'b1;
        wait_n(4);
        check_pos("R1");

        for (int i = 0; i < 16; i++) do_step(1'b1, 1'b1, "R3");
        for (int i = 0; i < 16; i++) do_step(1'b0, 1'b1, "R4");
        for (int i = 0; i < 8; i++)  do_step(1'b1, 1'b0, "R5");
        for (int i = 0; i < 8; i++)  do_step(1'b0, 1'b0, "R5");

        for (int k = 0; k < 4; k++) begin
            do_step(1'b1, 1'b1, "R3");
            do_step(k[0], 1'b0, "R6");
            do_step(1'b0, 1'b1, "R4");
            do_step(~k[0], 1'b0, "R6");
        end

        do_step(1'b1, 1'b1, "R7");
        do_step(1'b1, 1'b1, "R7");

        step_in = 1'b1;
        wait_n(2);
        rst_n = 1'b0;
        model_pos = 0;
        wait_n(3);
        check_pos("R1");
        rst_n = 1'b1;
        wait_n(10);
        check_pos("R8");
        step_in = 1'b0;
        wait_n(6);
        check_pos("R8");
        do_step(1'b1, 1'b1, "R8");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule